// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small direct-mapped cache that sits between a processor's word-wide load/store port and a slower memory port. Each word address is split into two parts. The low bits select one line, and the remaining high bits are kept in that line as a tag. A lookup compares the stored tag with the address tag and checks the line's valid flag. A read that hits returns its word in the same cycle without stalling.

A read that misses stalls the processor. The block then fetches the word over the memory handshake and installs it in the line, replacing whatever the line held. The read is then replayed and completes as a hit.

Every write is passed on to memory, and the processor stalls until memory acknowledges it. A write that hits also updates the cached word. A write that misses leaves the cache untouched. All lines start empty after reset. Each line holds one word.

Top module: `wtc_cache`

## Requirements
- R1: The line of an access is its word address modulo the line count, taken from the low IDX_W address bits. The line count is 2**IDX_W. The upper ADDR_W-IDX_W bits are the tag. With the defaults (8 lines, 5-bit addresses), address 22 uses line 6 with tag 2, and address 26 uses line 2 with tag 3.
- R2: After reset every line is empty, so `cpu_hit` is 0 for every address. While no request is present, `mem_req` is 0.
- R3: `cpu_hit` is 1 in the first cycle of a request exactly when the selected line is valid and its stored tag equals the address tag.
- R4: A read that hits completes in its first cycle: `cpu_stall` is 0 and `cpu_rdata` holds the cached word.
- R5: A read that misses raises `cpu_stall`. In the following cycle it issues a memory read (`mem_req`=1, `mem_we`=0) for the same address. It installs the returned word and tag, and then completes with that word as a hit.
- R6: Every write raises a memory write (`mem_req`=1, `mem_we`=1) with the same address and data, and keeps `cpu_stall` at 1 until `mem_ack`. On a hit, the cached word is updated, so a later read of that address hits and returns the new data.
- R7: A write that misses allocates no line. A later read of that address misses and returns the written data from memory.
- R8: `cpu_stall` is 0 in any cycle where `cpu_req` is 0.
- R9: Once raised, `mem_req` stays at 1, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle that `mem_ack` is 1.
- R10: A read miss replaces the line's previous contents. After address 18 (line 2, tag 2) is read, address 26 (line 2, tag 3) misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until a cycle with `cpu_stall` low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when the read completes |
| cpu_stall | output | 1 | Request not yet satisfied this cycle |
| cpu_hit | output | 1 | Lookup result for the presented address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, fill read when 0 |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Fill data, sampled with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the memory access |

## Verification
A wrong tag, a stuck valid flag or a bad line index shows up on `cpu_hit` and `cpu_stall` in the very first cycle of the next access to that line. A miss that should have been a hit adds a memory read within one cycle, and a false hit returns stale `cpu_rdata` at once. A corrupted cached word stays hidden until a later read hits that line. For that reason the trace re-reads lines after fills, after write hits, after write misses and after a conflict replacement, and compares every returned word against a memory model kept by the bench.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       lookup_hit,
  input  logic       mem_ack,
  output wtc_state_e state,
  output logic       launch,
  output logic       cpu_stall,
  output logic       mem_req,
  output logic       mem_we,
  output logic       fill_ack,
  output logic       wr_hit_upd
);
  wtc_state_e state_q, state_d;
  logic       in_idle, rd_hit_done, wr_done;

  assign in_idle     = (state_q == ST_IDLE);
  assign launch      = in_idle && cpu_req && (cpu_we || !lookup_hit);
  assign rd_hit_done = in_idle && cpu_req && !cpu_we && lookup_hit;
  assign wr_done     = (state_q == ST_WRITE) && mem_ack;
  assign fill_ack    = (state_q == ST_FILL) && mem_ack;
  assign wr_hit_upd  = wr_done && lookup_hit;
  assign cpu_stall   = cpu_req && !(rd_hit_done || wr_done);
  assign mem_req     = !in_idle;
  assign mem_we      = (state_q == ST_WRITE);
  assign state       = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (launch) state_d = cpu_we ? ST_WRITE : ST_FILL;
      ST_FILL:  if (mem_ack) state_d = ST_IDLE;
      ST_WRITE: if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              cpu_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  wtc_state_e        state;
  logic              in_idle, launch, fill_ack, wr_hit_upd;
  logic [ADDR_W-1:0] req_addr_q, look_addr;
  logic [DATA_W-1:0] req_wdata_q;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic              lookup_hit;
  logic [DATA_W-1:0] line_word;

  assign in_idle   = (state == ST_IDLE);
  assign look_addr = in_idle ? cpu_addr : req_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else if (launch) begin
      req_addr_q  <= cpu_addr;
      req_wdata_q <= cpu_wdata;
    end
  end

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (line_of(look_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .wr_en    (fill_ack),
    .wr_idx   (line_of(req_addr_q)),
    .wr_tag   (tag_of(req_addr_q))
  );

  wtc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (line_of(look_addr)),
    .rd_data (line_word),
    .wr_en   (fill_ack || wr_hit_upd),
    .wr_idx  (line_of(req_addr_q)),
    .wr_data (fill_ack ? mem_rdata : req_wdata_q)
  );

  assign lookup_hit = line_valid && (line_tag == tag_of(look_addr));

  wtc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .lookup_hit (lookup_hit),
    .mem_ack    (mem_ack),
    .state      (state),
    .launch     (launch),
    .cpu_stall  (cpu_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .fill_ack   (fill_ack),
    .wr_hit_upd (wr_hit_upd)
  );

  assign cpu_hit   = lookup_hit;
  assign cpu_rdata = line_word;
  assign mem_addr  = req_addr_q;
  assign mem_wdata = req_wdata_q;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_stall,
  input logic              cpu_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              in_idle,
  input logic              fill_ack
);
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && cpu_req && !cpu_we && cpu_hit |-> !cpu_stall); // R4

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && cpu_req && !cpu_we && !cpu_hit |-> cpu_stall); // R5

  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && cpu_req && !cpu_we && !cpu_hit
      |=> mem_req && !mem_we && (mem_addr == $past(cpu_addr))); // R5

  AST_FILL_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack |=> in_idle && (!cpu_req || (cpu_addr != mem_addr) || cpu_hit)); // R5

  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && cpu_req && cpu_we
      |=> mem_req && mem_we && (mem_addr == $past(cpu_addr))
          && (mem_wdata == $past(cpu_wdata))); // R6

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall); // R8

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack
      |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
endmodule

bind wtc_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_stall (cpu_stall),
  .cpu_hit   (cpu_hit),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .in_idle   (in_idle),
  .fill_ack  (fill_ack)
);

// File: tb/wtc_cache_test.sv
module wtc_cache_test;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic              cpu_stall, cpu_hit;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              mem_ack = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  int n_mem_writes = 0;
  int n_mem_reads  = 0;
  int lat_cnt = 0;

  logic [DATA_W-1:0] mem_model [WORDS];
  bit                ref_valid [LINES];
  int                ref_tag   [LINES];

  always #2 clk = ~clk;

  wtc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uut (.*);

  // Memory model: acknowledges two cycles after a request is seen.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (rst_n && mem_req) begin
      lat_cnt = lat_cnt + 1;
      if (lat_cnt == 2) begin
        lat_cnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_model[mem_addr] = mem_wdata;
          n_mem_writes++;
        end else begin
          mem_rdata <= mem_model[mem_addr];
          n_mem_reads++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input int a);
    return ref_valid[a % LINES] && (ref_tag[a % LINES] == a / LINES);
  endfunction

  task automatic access(input bit we, input int a, input logic [DATA_W-1:0] wd,
                        output bit hit, output int stalls,
                        output logic [DATA_W-1:0] rd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = wd;
    #1;
    hit = cpu_hit;
    stalls = 0;
    while (cpu_stall && stalls < 50) begin
      @(negedge clk); #1;
      stalls++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (!we && !ref_hit(a)) begin
      ref_valid[a % LINES] = 1'b1;
      ref_tag[a % LINES] = a / LINES;
    end
  endtask

  task automatic read_and_check(input int a, input string req);
    bit hit; int st; logic [DATA_W-1:0] rd; bit exp_hit;
    logic [DATA_W-1:0] exp_data;
    exp_hit = ref_hit(a);
    exp_data = mem_model[a];
    access(1'b0, a, '0, hit, st, rd);
    check(hit == exp_hit, {req, " hit/miss"}, DATA_W'(hit), DATA_W'(exp_hit));
    check((st == 0) == exp_hit, {req, " stall vs hit"}, DATA_W'(st), DATA_W'(!exp_hit));
    check(rd == exp_data, {req, " read data"}, rd, exp_data);
  endtask

  task automatic t_reset_state;
    bit any_hit = 0;
    @(negedge clk); #1;
    check(!cpu_stall, "R8 stall low without request", DATA_W'(cpu_stall), 0);
    check(!mem_req, "R2 no memory request after reset", DATA_W'(mem_req), 0);
    for (int a = 0; a < WORDS; a++) begin
      cpu_addr = ADDR_W'(a); #1;
      if (cpu_hit) any_hit = 1;
    end
    check(!any_hit, "R2 all lines empty after reset", DATA_W'(any_hit), 0);
  endtask

  task automatic t_trace;
    int trace [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
    for (int i = 0; i < 8; i++) read_and_check(trace[i], "R1 R3 R4 R5 trace");
    // address 18 shares line 2 with 26 and has evicted it
    read_and_check(26, "R10 conflict replacement");
    check(ref_valid[2] && ref_tag[2] == 3, "R10 line 2 now tag 3",
          DATA_W'(ref_tag[2]), 3);
  endtask

  task automatic t_write_hit;
    bit hit; int st; logic [DATA_W-1:0] rd; int w0;
    w0 = n_mem_writes;
    access(1'b1, 22, 32'hCAFE_0022, hit, st, rd);
    check(hit, "R6 write to cached line is a hit", DATA_W'(hit), 1);
    check(st > 0, "R6 write stalls until ack", DATA_W'(st), 1);
    check(n_mem_writes == w0 + 1, "R6 write forwarded", DATA_W'(n_mem_writes), DATA_W'(w0 + 1));
    check(mem_model[22] == 32'hCAFE_0022, "R6 memory data", mem_model[22], 32'hCAFE_0022);
    read_and_check(22, "R6 cached word updated");
  endtask

  task automatic t_write_miss;
    bit hit; int st; logic [DATA_W-1:0] rd; int w0;
    w0 = n_mem_writes;
    access(1'b1, 5, 32'hBEEF_0005, hit, st, rd);
    check(!hit, "R7 write to empty line misses", DATA_W'(hit), 0);
    check(n_mem_writes == w0 + 1, "R7 write miss forwarded", DATA_W'(n_mem_writes), DATA_W'(w0 + 1));
    @(negedge clk);
    cpu_addr = ADDR_W'(5); #1;
    check(!cpu_hit, "R7 no allocation on write miss", DATA_W'(cpu_hit), 0);
    read_and_check(5, "R7 read after write miss");
  endtask

  task automatic t_fill_traffic;
    int r0;
    r0 = n_mem_reads;
    read_and_check(13, "R5 miss fetch");
    check(n_mem_reads == r0 + 1, "R5 one fill read per miss", DATA_W'(n_mem_reads), DATA_W'(r0 + 1));
    r0 = n_mem_reads;
    read_and_check(13, "R4 repeat hit");
    check(n_mem_reads == r0, "R4 hit issues no memory read", DATA_W'(n_mem_reads), DATA_W'(r0));
  endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < WORDS; i++) mem_model[i] = 32'hA000_0000 + 32'(i * 3);
    for (int i = 0; i < LINES; i++) begin ref_valid[i] = 0; ref_tag[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_trace();
    t_write_hit();
    t_write_miss();
    t_fill_traffic();
    repeat (4) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule